// File: doc/BRIEF.md
# Flag-Setting Integer ALU

A registered 32-bit execution unit for a small register-register processor. Each cycle with `valid_i` high it takes a source operand and the current destination register value. It performs one of six operations: add, subtract, compare, OR, XOR or bit-test. One clock edge later it presents the result, a write-back enable and a fresh set of zero, negative, carry and overflow flags.

Compare and bit-test only update the flags and never request write-back. The other four operations return their result to the destination register. Every logical operation forces carry and overflow to zero. The register file, decode and the remaining status-word bits belong to the surrounding core.

Top module: `flag_alu`

## Requirements
- R1: Opcode 000 (add) yields dst + src modulo 2^32 on `result_o`, with `wb_en_o` high.
- R2: Add sets C when the unsigned sum wraps past 2^32. It sets V when both operands share a sign bit and the sum's sign bit differs from it.
- R3: Opcode 001 (sub) yields dst − src on `result_o` with `wb_en_o` high. C is set when src > dst as unsigned values. V is set when the operand signs differ and the result sign differs from dst's sign.
- R4: Opcode 010 (compare) sets the flags exactly as sub on the same operands (dst − src). It holds `wb_en_o` low and leaves `result_o` unchanged.
- R5: Opcodes 011 (OR) and 100 (XOR) write back dst | src and dst ^ src respectively, and force C and V to 0.
- R6: Opcode 101 (bit-test) sets Z and N from dst & src, forces C and V to 0, holds `wb_en_o` low and leaves `result_o` unchanged.
- R7: For every operation, Z is 1 exactly when the 32-bit operation value is zero, and N equals its bit 31.
- R8: Outputs appear one clock after the input is accepted. `wb_en_o` and `flags_upd_o` are one-cycle pulses, and `flags_upd_o` is high for every accepted legal opcode.
- R9: Opcodes 110 and 111, or `valid_i` low, produce no write-back and no flag strobe, and leave `result_o` and `flags_o` unchanged.
- R10: While `rst_ni` is low, `result_o`, `flags_o`, `wb_en_o` and `flags_upd_o` are all zero.
- R11: `flags_o` is packed as {V, C, N, Z} in bits 3..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation accepted this cycle |
| op_i | input | 3 | Operation select |
| src_i | input | 32 | Source operand |
| dst_i | input | 32 | Destination register value |
| result_o | output | 32 | Value to write back |
| wb_en_o | output | 1 | Write-back strobe |
| flags_o | output | 4 | Status flags {V, C, N, Z} |
| flags_upd_o | output | 1 | Flag-update strobe |

## Verification
Several properties are checked on every cycle:
- flags and result stay frozen whenever nothing legal is accepted;
- write-back never occurs without a flag update;
- compare and bit-test never write back;
- logical operations clear carry and overflow;
- Z tracks a written-back result.

Only the bench's scenarios can show that the arithmetic is correct. That covers wrap-around carries, signed overflow at both extremes, borrow on sub and compare, and bit-test zero and negative cases. The bench checks these against an independent model over directed and pseudo-random operands.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_CMP  = 3'b010,
    OP_OR   = 3'b011,
    OP_XOR  = 3'b100,
    OP_BTST = 3'b101
  } alu_op_e;

  // packs as {v, c, n, z} in bits 3..0
  typedef struct packed {
    logic v;
    logic c;
    logic n;
    logic z;
  } flags_t;
endpackage

// File: rtl/flag_alu_arith.sv
module flag_alu_arith #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              sub_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o,
  output logic              v_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] sum, diff;

  always_comb begin
    sum  = dst_i + src_i;
    diff = dst_i - src_i;
    if (sub_i) begin
      res_o = diff;
      c_o   = src_i > dst_i;
      v_o   = (dst_i[MSB] != src_i[MSB]) && (diff[MSB] != dst_i[MSB]);
    end else begin
      res_o = sum;
      c_o   = (sum < dst_i) || (sum < src_i);
      v_o   = (dst_i[MSB] == src_i[MSB]) && (sum[MSB] != dst_i[MSB]);
    end
  end
endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
  import flag_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_OR:   res_o = dst_i | src_i;
      OP_XOR:  res_o = dst_i ^ src_i;
      default: res_o = dst_i & src_i;
    endcase
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  output logic [DATA_W-1:0] result_o,
  output logic              wb_en_o,
  output logic [3:0]        flags_o,
  output logic              flags_upd_o
);
  localparam int unsigned MSB = DATA_W - 1;

  alu_op_e           op;
  logic              is_arith, is_sub, legal, do_wb;
  logic [DATA_W-1:0] arith_res, logic_res, op_val;
  logic              arith_c, arith_v;
  flags_t            flags_d, flags_q;
  logic [DATA_W-1:0] result_q;
  logic              wb_q, upd_q;

  assign op       = alu_op_e'(op_i);
  assign is_sub   = (op == OP_SUB) || (op == OP_CMP);
  assign is_arith = (op == OP_ADD) || is_sub;
  assign legal    = valid_i && (op_i <= 3'b101);
  assign do_wb    = legal && (op != OP_CMP) && (op != OP_BTST);

  flag_alu_arith #(.DATA_W(DATA_W)) u_arith (
    .sub_i (is_sub),
    .dst_i (dst_i),
    .src_i (src_i),
    .res_o (arith_res),
    .c_o   (arith_c),
    .v_o   (arith_v)
  );

  flag_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .op_i  (op),
    .dst_i (dst_i),
    .src_i (src_i),
    .res_o (logic_res)
  );

  always_comb begin
    op_val    = is_arith ? arith_res : logic_res;
    flags_d.z = (op_val == '0);
    flags_d.n = op_val[MSB];
    flags_d.c = is_arith & arith_c;   // logical ops force 0
    flags_d.v = is_arith & arith_v;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      flags_q  <= '0;
      wb_q     <= 1'b0;
      upd_q    <= 1'b0;
    end else begin
      wb_q  <= do_wb;
      upd_q <= legal;
      if (legal)  flags_q  <= flags_d;
      if (do_wb)  result_q <= op_val;
    end
  end

  assign result_o    = result_q;
  assign flags_o     = flags_q;
  assign wb_en_o     = wb_q;
  assign flags_upd_o = upd_q;

  assert_wb_implies_upd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> flags_upd_o);

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && op_i <= 3'b101) |=> (!wb_en_o && !flags_upd_o &&
                                      $stable(flags_o) && $stable(result_o)));

  assert_no_wb_cmp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 3'b010 || op_i == 3'b101)) |=>
      (!wb_en_o && flags_upd_o && $stable(result_o)));

  assert_logic_clear_cv_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 3'b011 || op_i == 3'b100 || op_i == 3'b101)) |=>
      (flags_o[3:2] == 2'b00));

  assert_z_tracks_result_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> (flags_o[0] == (result_o == '0)) && (flags_o[1] == result_o[MSB]));

  always_comb begin
    if (!rst_ni) assert_reset_clear_R10: assert (flags_o == 4'b0);
  end
endmodule

// File: tb/tb_flag_alu.sv
module tb_flag_alu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = 3'b0;
  logic [31:0] src_i = '0, dst_i = '0;
  logic [31:0] result_o;
  logic        wb_en_o, flags_upd_o;
  logic [3:0]  flags_o;

  always #5 clk_i = ~clk_i;

  flag_alu dut (
    .clk_i, .rst_ni, .valid_i, .op_i, .src_i, .dst_i,
    .result_o, .wb_en_o, .flags_o, .flags_upd_o
  );

  typedef struct packed {
    logic        wb;
    logic        upd;
    logic [31:0] res;
    logic [3:0]  fl;
  } exp_t;

  exp_t   exp_q[$];
  string  tag_q[$];
  int     n_run = 0, n_fail = 0;
  logic [31:0] m_res = '0;
  logic [3:0]  m_fl = '0;
  bit     done = 0;

  task automatic check(string tag, logic [37:0] act, logic [37:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual wb=%0b upd=%0b res=%h fl=%b expected wb=%0b upd=%0b res=%h fl=%b",
               tag, act[37], act[36], act[35:4], act[3:0], exp[37], exp[36], exp[35:4], exp[3:0]);
    end
  endtask

  // model; flags packed {V,C,N,Z} (R11)
  task automatic step(input logic v, input logic [2:0] op, input logic [31:0] s,
                      input logic [31:0] d, input string tag);
    logic [32:0] w;
    logic [31:0] val;
    logic z, n, c, ov, legal, wb;
    exp_t e;
    valid_i = v; op_i = op; src_i = s; dst_i = d;
    legal = v && (op <= 3'b101);
    c = 0; ov = 0; val = '0;
    case (op)
      3'b000: begin w = {1'b0, d} + {1'b0, s}; val = w[31:0]; c = w[32];
                    ov = (d[31] == s[31]) && (val[31] != d[31]); end
      3'b001, 3'b010: begin val = d - s; c = (s > d);
                    ov = (d[31] != s[31]) && (val[31] != d[31]); end
      3'b011: val = d | s;
      3'b100: val = d ^ s;
      3'b101: val = d & s;
      default: ;
    endcase
    z = (val == 0); n = val[31];
    wb = legal && op != 3'b010 && op != 3'b101;
    if (legal) m_fl = {ov, c, n, z};
    if (wb) m_res = val;
    @(posedge clk_i);
    e.wb = wb; e.upd = legal; e.res = m_res; e.fl = m_fl;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk_i);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {wb_en_o, flags_upd_o, result_o, flags_o}, e);
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    repeat (3) @(negedge clk_i);
    valid_i = 1;
    op_i = 3'b000;
    src_i = 32'h5;
    dst_i = 32'h7;
    @(negedge clk_i);
    check("R10 reset", {wb_en_o, flags_upd_o, result_o, flags_o}, 38'h0);
    valid_i = 0;
    rst_ni = 1;
    @(negedge clk_i);

    step(1, 3'b000, 32'd5,        32'd7,        "R1 add");
    step(1, 3'b000, 32'd1,        32'hFFFF_FFFF, "R2 add wrap carry+Z");
    step(1, 3'b000, 32'd1,        32'h7FFF_FFFF, "R2 add pos overflow");
    step(1, 3'b000, 32'h8000_0000, 32'h8000_0000, "R2 add neg overflow carry");
    step(1, 3'b001, 32'd3,        32'd10,       "R3 sub");
    step(1, 3'b001, 32'd2,        32'd1,        "R3 sub borrow");
    step(1, 3'b001, 32'd1,        32'h8000_0000, "R3 sub overflow");
    step(1, 3'b010, 32'd9,        32'd9,        "R4 cmp equal");
    step(1, 3'b010, 32'd10,       32'd4,        "R4 cmp borrow");
    step(1, 3'b010, 32'hFFFF_FFFF, 32'h7FFF_FFFF, "R4 cmp overflow");
    step(1, 3'b011, 32'h8000_0000, 32'h0000_00F0, "R5 or");
    step(1, 3'b000, 32'd1,        32'hFFFF_FFFF, "R5 set C before xor");
    step(1, 3'b100, 32'hA5A5_A5A5, 32'hA5A5_A5A5, "R5 xor zero clears C");
    step(1, 3'b101, 32'h0F0F_0000, 32'hF0F0_FFFF, "R6 btst zero");
    step(1, 3'b101, 32'h8000_0001, 32'hC000_0000, "R6 btst negative");
    step(1, 3'b001, 32'd0,        32'h8000_0000, "R7 N from bit31");
    step(1, 3'b110, 32'd1,        32'd1,        "R9 illegal op 110");
    step(1, 3'b111, 32'd0,        32'd0,        "R9 illegal op 111");
    step(0, 3'b000, 32'd0,        32'd0,        "R9 valid low");
    step(1, 3'b000, 32'h8000_0000, 32'h8000_0000, "R11 packing V and C");
    step(0, 3'b011, 32'hFFFF_FFFF, 32'd0,        "R8 strobe one cycle");
    seed = 32'h1234_5678;
    for (int i = 0; i < 60; i++) begin
      logic [31:0] a, b;
      seed = seed * 32'd1664525 + 32'd1013904223; a = seed;
      seed = seed * 32'd1664525 + 32'd1013904223; b = seed;
      if (i % 5 == 0) b = a;
      step(seed[30], 3'(seed[18:16]), a, b, "R8 random");
    end
    step(0, 3'b000, 32'd0, 32'd0, "R9 drain");
    @(negedge clk_i);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule